// File: doc/BRIEF.md
# Age-Ordered Dual-Grant Issue Arbiter

This block picks which instructions leave a 20-slot integer issue queue each cycle. Every occupied slot belongs to one of two cluster halves, upper or lower. The side is fixed when the slot is filled and never changes while the slot is in use. The block also keeps the relative age of all occupied slots, so that it knows which one was filled first.

Each cycle the wakeup logic raises per-slot request bits for four subclusters: two in the upper half and two in the lower half. Each half has its own arbiter. In each half, the first subcluster takes the oldest slot that asks for it. The second subcluster then takes the oldest remaining slot that asks for it, leaving out the slot already granted. Up to four slots can therefore issue in one cycle. Grants are combinational outputs: a one-hot vector, a valid bit and a binary index for each subcluster. A granted slot is released at the next clock edge.

The surrounding queue fills slots through a single insert port. It watches the busy vector to find free slots.

Top module: `issue_dual_arbiter`

## Requirements
- R1: After a clock edge with `rst_n` low, every slot is free and no subcluster shows a grant.
- R2: An insert to a free slot (index below 20) makes the slot busy after the next edge, with side taken from `ins_upper` (1 = upper). That slot becomes younger than every other busy slot.
- R3: An insert to a busy slot, or to an index of 20 or above, is ignored. Busy state, side and age stay unchanged.
- R4: A request bit counts only when its slot is busy and the slot's side matches the subcluster. Subcluster order is 0 = upper-0, 1 = upper-1, 2 = lower-0, 3 = lower-1; subclusters 0 and 1 serve upper slots, 2 and 3 serve lower slots.
- R5: Subcluster 0 of each half grants the oldest slot among its eligible requesters.
- R6: Each subcluster grants at most one slot. Its one-hot vector is zero when its valid bit is low. When valid is high, the one-hot vector has exactly the bit whose number is the index.
- R7: No slot is granted twice in a cycle. Subcluster 1 of a half grants the oldest eligible requester other than the slot granted by subcluster 0, so subcluster 0 has precedence for a slot that asks both.
- R8: A granted slot is free after the next edge, and it can then be filled again as the youngest slot.
- R9: The two halves arbitrate independently, so four slots can be granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_valid | input | 1 | Insert request |
| ins_slot | input | 5 | Slot to fill |
| ins_upper | input | 1 | Side of the inserted slot, 1 = upper half |
| req | input | 4x20 | Request bits per subcluster (0..3 = U0, U1, L0, L1), one bit per slot |
| gnt_oh | output | 4x20 | One-hot grant per subcluster |
| gnt_vld | output | 4 | Grant present per subcluster |
| gnt_idx | output | 4x5 | Granted slot index per subcluster |
| slot_busy | output | 20 | Occupied slots |

## Verification
The bound checker tests every cycle that grants are one-hot and agree with their index. It also tests that a grant always goes to a busy slot on the correct side that actually requested it, and that no older eligible requester was passed over. Every cycle it further checks that the two subclusters of a half never share a slot, that granted slots are freed, that accepted inserts take the given side, and that busy slots which were not granted keep their side. Exact order after long mixes of inserts and releases, slot reuse as the youngest, ignored inserts, and four simultaneous grants can only be shown by the bench. The bench runs its sequence-number reference model every cycle on directed and random traffic.

// File: rtl/iq_arb_pkg.sv
// Package: shared subcluster numbering for the issue arbiter.
// Assumes subclusters 0/1 form the upper half and 2/3 the lower half.
package iq_arb_pkg;
    typedef enum logic [1:0] {
        SUB_U0 = 2'd0,
        SUB_U1 = 2'd1,
        SUB_L0 = 2'd2,
        SUB_L1 = 2'd3
    } sub_e;
    localparam int NUM_SUB      = 4;
    localparam int SUB_PER_HALF = 2;
    localparam int NUM_HALF     = NUM_SUB / SUB_PER_HALF;
endpackage

// File: rtl/iq_age_tracker.sv
// Slot state: busy flag, side bit and an age matrix.
// older_q[i][j] = 1 means slot i was filled before slot j.
// Assumes at most one insert per cycle. An accepted insert makes its slot
// younger than every other slot. Rows of free slots are don't-care.
module iq_age_tracker #(
    parameter int ENTRIES = 20,
    parameter int IW      = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ins_valid,
    input  logic [IW-1:0]                   ins_slot,
    input  logic                            ins_upper,
    input  logic [ENTRIES-1:0]              release_mask,
    output logic [ENTRIES-1:0]              busy_q,
    output logic [ENTRIES-1:0]              upper_q,
    output logic [ENTRIES-1:0][ENTRIES-1:0] older_q
);
    logic [ENTRIES-1:0] accept;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        // accept an insert only into a free slot whose index matches
        assign accept[i] = ins_valid && (ins_slot == IW'(i)) && !busy_q[i];

        // busy and side flags: fill on accept, clear on grant
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[i]  <= 1'b0;
                upper_q[i] <= 1'b0;
            end else if (accept[i]) begin
                busy_q[i]  <= 1'b1;
                upper_q[i] <= ins_upper;
            end else if (release_mask[i]) begin
                busy_q[i]  <= 1'b0;
            end
        end

        for (genvar j = 0; j < ENTRIES; j++) begin : g_pair
            if (i == j) begin : g_diag
                assign older_q[i][j] = 1'b0;
            end else begin : g_cell
                // age bit: a new slot is older than nobody and younger than all
                always_ff @(posedge clk) begin
                    if (!rst_n)          older_q[i][j] <= 1'b0;
                    else if (accept[i])  older_q[i][j] <= 1'b0;
                    else if (accept[j])  older_q[i][j] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/iq_oldest_picker.sv
// Oldest-first picker: a candidate wins when no other candidate is older.
// Assumes the age matrix orders all candidates totally, so at most one wins.
module iq_oldest_picker #(
    parameter int ENTRIES = 20
) (
    input  logic [ENTRIES-1:0]              cand,
    input  logic [ENTRIES-1:0][ENTRIES-1:0] older,
    output logic [ENTRIES-1:0]              win
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cand
        logic [ENTRIES-1:0] beaten_by;
        for (genvar j = 0; j < ENTRIES; j++) begin : g_col
            assign beaten_by[j] = older[j][i];
        end
        // win when candidate and no older candidate exists
        assign win[i] = cand[i] && ((cand & beaten_by) == '0);
    end
endmodule

// File: rtl/iq_half_arbiter.sv
// Arbiter for one half: subcluster A picks the oldest eligible slot first,
// then subcluster B picks the oldest eligible slot other than A's winner.
// Assumes side_ok already masks busy slots of this half.
module iq_half_arbiter #(
    parameter int ENTRIES = 20,
    parameter int IW      = 5
) (
    input  logic [ENTRIES-1:0]              side_ok,
    input  logic [ENTRIES-1:0]              req_a,
    input  logic [ENTRIES-1:0]              req_b,
    input  logic [ENTRIES-1:0][ENTRIES-1:0] older,
    output logic [ENTRIES-1:0]              oh_a,
    output logic [ENTRIES-1:0]              oh_b,
    output logic                            vld_a,
    output logic                            vld_b,
    output logic [IW-1:0]                   idx_a,
    output logic [IW-1:0]                   idx_b
);
    logic [ENTRIES-1:0] cand_a, cand_b;

    assign cand_a = side_ok & req_a;
    assign cand_b = side_ok & req_b & ~oh_a;

    iq_oldest_picker #(.ENTRIES(ENTRIES)) u_pick_a (
        .cand(cand_a), .older(older), .win(oh_a));
    iq_oldest_picker #(.ENTRIES(ENTRIES)) u_pick_b (
        .cand(cand_b), .older(older), .win(oh_b));

    assign vld_a = |oh_a;
    assign vld_b = |oh_b;

    // encode both one-hot winners to binary indices
    always_comb begin
        idx_a = '0;
        idx_b = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (oh_a[i]) idx_a = idx_a | IW'(i);
            if (oh_b[i]) idx_b = idx_b | IW'(i);
        end
    end
endmodule

// File: rtl/issue_dual_arbiter.sv
// Top: 20-slot issue arbiter with two independent halves, four grants max.
// Assumes requests come from wakeup logic and may be set for any slot;
// the block itself masks free slots and wrong-side requests.
module issue_dual_arbiter
    import iq_arb_pkg::*;
#(
    parameter int ENTRIES = 20,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ins_valid,
    input  logic [IW-1:0]                   ins_slot,
    input  logic                            ins_upper,
    input  logic [NUM_SUB-1:0][ENTRIES-1:0] req,
    output logic [NUM_SUB-1:0][ENTRIES-1:0] gnt_oh,
    output logic [NUM_SUB-1:0]              gnt_vld,
    output logic [NUM_SUB-1:0][IW-1:0]      gnt_idx,
    output logic [ENTRIES-1:0]              slot_busy
);
    logic [ENTRIES-1:0]              slot_upper;
    logic [ENTRIES-1:0][ENTRIES-1:0] age_older;
    logic [ENTRIES-1:0]              granted_any;

    // release every slot granted by any subcluster
    always_comb begin
        granted_any = '0;
        for (int s = 0; s < NUM_SUB; s++) granted_any = granted_any | gnt_oh[s];
    end

    iq_age_tracker #(.ENTRIES(ENTRIES), .IW(IW)) u_track (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_slot(ins_slot), .ins_upper(ins_upper),
        .release_mask(granted_any),
        .busy_q(slot_busy), .upper_q(slot_upper), .older_q(age_older));

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        localparam int SA = h * SUB_PER_HALF;
        localparam int SB = SA + 1;
        logic [ENTRIES-1:0] side_ok;
        if (h == 0) begin : g_up
            assign side_ok = slot_busy & slot_upper;
        end else begin : g_lo
            assign side_ok = slot_busy & ~slot_upper;
        end
        iq_half_arbiter #(.ENTRIES(ENTRIES), .IW(IW)) u_half (
            .side_ok(side_ok), .req_a(req[SA]), .req_b(req[SB]),
            .older(age_older),
            .oh_a(gnt_oh[SA]), .oh_b(gnt_oh[SB]),
            .vld_a(gnt_vld[SA]), .vld_b(gnt_vld[SB]),
            .idx_a(gnt_idx[SA]), .idx_b(gnt_idx[SB]));
    end
endmodule

// File: rtl/issue_dual_arbiter_chk.sv
// Checker: cycle-by-cycle properties of the issue arbiter, bound to the top.
// Assumes subclusters 0/1 are upper and 2/3 lower.
module issue_dual_arbiter_chk #(
    parameter int ENTRIES = 20,
    parameter int IW      = 5
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            ins_valid,
    input logic [IW-1:0]                   ins_slot,
    input logic                            ins_upper,
    input logic [3:0][ENTRIES-1:0]         req,
    input logic [3:0][ENTRIES-1:0]         gnt_oh,
    input logic [3:0]                      gnt_vld,
    input logic [3:0][IW-1:0]              gnt_idx,
    input logic [ENTRIES-1:0]              slot_busy,
    input logic [ENTRIES-1:0]              slot_upper,
    input logic [ENTRIES-1:0][ENTRIES-1:0] age_older
);
    logic [3:0]         passed_over;
    logic [ENTRIES-1:0] all_gnt;
    logic               ins_ok;

    // gather granted slots and whether the current insert will be accepted
    always_comb begin
        all_gnt = gnt_oh[0] | gnt_oh[1] | gnt_oh[2] | gnt_oh[3];
        ins_ok  = ins_valid && ({1'b0, ins_slot} < (IW+1)'(ENTRIES))
                  && !slot_busy[ins_slot];
    end

    // flag a grant that skipped an older eligible requester (R5, R7)
    always_comb begin
        for (int s = 0; s < 4; s++) begin
            passed_over[s] = 1'b0;
            for (int w = 0; w < ENTRIES; w++) begin
                for (int o = 0; o < ENTRIES; o++) begin
                    if (gnt_oh[s][w] && req[s][o] && slot_busy[o]
                        && (slot_upper[o] == (s < 2)) && age_older[o][w]
                        && !((s % 2 == 1) && gnt_oh[s-1][o]))
                        passed_over[s] = 1'b1;
                end
            end
        end
    end

    for (genvar s = 0; s < 4; s++) begin : g_sub
        a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_oh[s]) && (gnt_vld[s] == (gnt_oh[s] != '0)));
        a_r6_index: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[s] |-> (gnt_oh[s] == (ENTRIES'(1) << gnt_idx[s])));
        a_r4_eligible: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_oh[s] & ~(req[s] & slot_busy
                & ((s < 2) ? slot_upper : ~slot_upper))) == '0);
        a_r5_oldest: assert property (@(posedge clk) disable iff (!rst_n)
            !passed_over[s]);
        a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[s] |=> ((slot_busy & $past(gnt_oh[s])) == '0));
    end

    a_r7_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_oh[0] & gnt_oh[1]) == '0) && ((gnt_oh[2] & gnt_oh[3]) == '0));
    a_r2_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ok |=> (slot_busy[$past(ins_slot)]
                    && (slot_upper[$past(ins_slot)] == $past(ins_upper))));
    a_r3_held: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_busy & ~all_gnt) != '0 |=>
            ((($past(slot_busy & ~all_gnt)) & ~slot_busy) == '0)
            && ((($past(slot_busy & ~all_gnt)) & (slot_upper ^ $past(slot_upper))) == '0));
endmodule

bind issue_dual_arbiter issue_dual_arbiter_chk #(.ENTRIES(ENTRIES), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_slot(ins_slot),
    .ins_upper(ins_upper), .req(req), .gnt_oh(gnt_oh), .gnt_vld(gnt_vld),
    .gnt_idx(gnt_idx), .slot_busy(slot_busy), .slot_upper(slot_upper),
    .age_older(age_older));

// File: tb/issue_dual_arbiter_bench.sv
module issue_dual_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 20;
    localparam int IW = 5;

    logic              clk;
    logic              rst_n;
    logic              ins_valid;
    logic [IW-1:0]     ins_slot;
    logic              ins_upper;
    logic [3:0][N-1:0] req;
    logic [3:0][N-1:0] gnt_oh;
    logic [3:0]        gnt_vld;
    logic [3:0][IW-1:0] gnt_idx;
    logic [N-1:0]      slot_busy;

    issue_dual_arbiter #(.ENTRIES(N)) u_issue_dual_arbiter (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_slot(ins_slot),
        .ins_upper(ins_upper), .req(req), .gnt_oh(gnt_oh), .gnt_vld(gnt_vld),
        .gnt_idx(gnt_idx), .slot_busy(slot_busy));

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors;
    int miscompares;
    bit done;
    bit m_busy [N];
    bit m_upper[N];
    int m_seq  [N];
    int seq_ctr;
    int e_idx  [4];

    // reference: oldest = smallest insertion sequence number
    function automatic void model_pick();
        for (int s = 0; s < 4; s++) begin
            int best;
            e_idx[s] = -1;
            best = 0;
            for (int i = 0; i < N; i++) begin
                if (m_busy[i] && (m_upper[i] == (s < 2)) && req[s][i]
                    && !((s % 2 == 1) && (e_idx[s-1] == i))
                    && (e_idx[s] < 0 || m_seq[i] < best)) begin
                    e_idx[s] = i;
                    best = m_seq[i];
                end
            end
        end
    endfunction

    task automatic idle();
        ins_valid = 1'b0;
        ins_slot  = '0;
        ins_upper = 1'b0;
        req       = '0;
    endtask

    // compare all outputs against the model, then advance one clock
    task automatic step(input string tag);
        logic [N-1:0] exp_oh;
        logic [N-1:0] exp_busy;
        bit keep[N];
        model_pick();
        #2;
        for (int s = 0; s < 4; s++) begin
            exp_oh = (e_idx[s] >= 0) ? (N'(1) << e_idx[s]) : '0;
            vectors++;
            if (gnt_vld[s] !== (e_idx[s] >= 0) || gnt_oh[s] !== exp_oh
                || (e_idx[s] >= 0 && gnt_idx[s] !== IW'(e_idx[s]))) begin
                miscompares++;
                $display("FAIL %s sub%0d: actual vld=%b oh=%h idx=%0d expected vld=%b oh=%h idx=%0d",
                         tag, s, gnt_vld[s], gnt_oh[s], gnt_idx[s],
                         e_idx[s] >= 0, exp_oh, e_idx[s]);
            end
        end
        for (int i = 0; i < N; i++) exp_busy[i] = m_busy[i];
        vectors++;
        if (slot_busy !== exp_busy) begin
            miscompares++;
            $display("FAIL %s busy: actual %h expected %h", tag, slot_busy, exp_busy);
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) keep[i] = m_busy[i];
        for (int s = 0; s < 4; s++) if (e_idx[s] >= 0) m_busy[e_idx[s]] = 1'b0;
        if (ins_valid && ins_slot < N && !keep[ins_slot]) begin
            m_busy[ins_slot]  = 1'b1;
            m_upper[ins_slot] = ins_upper;
            m_seq[ins_slot]   = seq_ctr;
            seq_ctr++;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic put(input int slot, input bit up, input string tag);
        ins_valid = 1'b1;
        ins_slot  = IW'(slot);
        ins_upper = up;
        step(tag);
    endtask

    initial begin
        vectors = 0; miscompares = 0; done = 0; seq_ctr = 0;
        for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_upper[i] = 0; m_seq[i] = 0; end
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        step("R1");                                   // reset state
        req = '1; step("R4");                         // requests on empty queue
        // R2: fill upper 5,3,19 and lower 12,0
        put(5, 1, "R2"); put(3, 1, "R2"); put(12, 0, "R2");
        put(0, 0, "R2"); put(19, 1, "R2");
        // R3: insert into busy slot 5 as lower, and out of range slot 25
        put(5, 0, "R3"); put(25, 1, "R3");
        req[2] = N'(1) << 5; step("R3");             // slot 5 stays upper
        req[0] = (N'(1) << 12) | (N'(1) << 0); step("R4"); // wrong side
        // R5: oldest upper wins U0 (slot 5)
        req[0] = '1; step("R5");
        // R8: slot 5 free now, refill -> youngest
        put(5, 1, "R8");
        // R7: U0 and U1 both ask all: oldest 3 then 19
        req[0] = '1; req[1] = '1; step("R7");
        // refill and R9: four grants at once
        put(3, 1, "R9"); put(7, 0, "R9"); put(8, 1, "R9");
        req = '1; step("R9");
        step("R8");
        // R7: U1 asks only the oldest, U0 asks everything
        put(10, 1, "R7"); put(11, 1, "R7");
        req[0] = '1; req[1] = N'(1) << 8; step("R7");
        // random traffic
        for (int k = 0; k < 400; k++) begin
            ins_valid = ($urandom % 4) != 0;
            ins_slot  = IW'($urandom % 24);
            ins_upper = $urandom % 2;
            for (int s = 0; s < 4; s++) req[s] = N'($urandom & $urandom);
            step("R9");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R1: actual no completion expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule